// File: doc/BRIEF.md
# Outbound Address Translation Window Table

This block maps 64-bit host-side request addresses onto link-side addresses through a small table of programmable windows. Software programs each window through a word-wide write port. A window holds a source base, a size, a translated base and two type codes: a resource class and a transaction-packet type. Every window spans a power-of-two number of bytes, and its source base is aligned to that span.

For each presented request, all enabled windows are compared in parallel. The lowest-numbered window that contains the address supplies the result. The address bits above the window span come from the translated base, and the bits inside the span pass through from the request. The result is registered and arrives one clock after the request. A request that no window claims comes out flagged as a miss with all-zero fields.

Top module: `xlat_window_table`

## Requirements
- R1: Window n (0..7) occupies the byte addresses 0x800 + 0x20*n onward. Its registers sit at these offsets: 0x00 source low word, 0x04 source high word, 0x08 translated low word, 0x0C translated high word, 0x10 parameter word. A write to any other address changes no window.
- R2: In the source low word, bit 0 enables the window and bits 6:1 hold a size code c, giving a span of 2^(c+1) bytes. Bits 6:0 of the source base are taken as zero, and c = 63 spans the whole 64-bit space.
- R3: A request hits a window when that window is enabled and request bits 63:c+1 equal the same bits of the window's source base.
- R4: On a hit, the output address is made of translated-base bits 63:c+1 and request bits c:0. Translated-base bits c:0 are ignored.
- R5: On a hit, parameter bits 3:0 appear on the resource-ID output (0 = memory, 1 = I/O) and parameter bits 18:16 appear on the packet-type output (0 = memory, 2 = I/O).
- R6: When several enabled windows contain the address, the lowest-numbered one supplies the result.
- R7: A request sampled with req_valid high at a clock edge produces rsp_valid high with its results after that edge, and only then. Back-to-back requests give back-to-back results.
- R8: A valid miss gives rsp_hit = 0 with a zero address, zero packet type and zero resource ID.
- R9: After reset, every window is disabled, so all requests miss, and rsp_valid and rsp_hit are low.
- R10: A window whose enable bit is cleared never hits, even when the address falls inside its range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Host-side request address |
| rsp_valid | output | 1 | Result valid, one clock after the request |
| rsp_hit | output | 1 | A window claimed the request |
| rsp_addr | output | 64 | Translated address, zero on a miss |
| rsp_pkt_type | output | 3 | Packet type of the winning window |
| rsp_res_id | output | 4 | Resource ID of the winning window |

## Verification
A register write takes effect at the clock edge that samples it, so a request driven on the following falling edge already sees the new window. Each result is due exactly one rising edge after its request is sampled. The bench drives requests on falling edges and reads the outputs on the next falling edge, which is the middle of the cycle in which the result is held. For back-to-back requests, the bench checks each result on the falling edge right after its own sampling edge, and then checks that rsp_valid drops one cycle after the last request.

// File: rtl/xlat_window_table.sv
module xlat_window_table #(
  parameter int NUM_WIN = 8,
  parameter int RAW = 12,
  parameter logic [RAW-1:0] TABLE_BASE = 12'h800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic [63:0] rsp_addr,
  output logic [2:0]  rsp_pkt_type,
  output logic [3:0]  rsp_res_id
);
  localparam int IDXW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [RAW-1:0]  rel;
  logic            in_tab;
  logic [IDXW-1:0] wsel;
  logic [4:0]      fld;

  assign rel    = reg_addr - TABLE_BASE;
  assign in_tab = (reg_addr >= TABLE_BASE) && ((rel >> 5) < RAW'(NUM_WIN));
  assign wsel   = rel[5 +: IDXW];
  assign fld    = rel[4:0];

  logic [NUM_WIN-1:0] hit_v;
  logic [63:0]        xl_v   [NUM_WIN];
  logic [6:0]         meta_v [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [31:0] src_lo, src_hi, tr_lo, tr_hi;
    logic [3:0]  res_id;
    logic [2:0]  pkt;
    logic [63:0] lowm, src;
    logic [5:0]  code;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_lo <= '0; src_hi <= '0; tr_lo <= '0; tr_hi <= '0;
        res_id <= '0; pkt <= '0;
      end else if (reg_we && in_tab && wsel == IDXW'(w)) begin
        case (fld)
          5'h00: src_lo <= reg_wdata;
          5'h04: src_hi <= reg_wdata;
          5'h08: tr_lo  <= reg_wdata;
          5'h0C: tr_hi  <= reg_wdata;
          5'h10: begin res_id <= reg_wdata[3:0]; pkt <= reg_wdata[18:16]; end
          default: ;
        endcase
      end
    end

    assign code = src_lo[6:1];
    assign lowm = (code == 6'd63) ? '1 : ((64'd1 << ({1'b0, code} + 7'd1)) - 64'd1);
    assign src  = {src_hi, src_lo[31:7], 7'b0};
    assign hit_v[w]  = src_lo[0] && ((req_addr & ~lowm) == (src & ~lowm));
    assign xl_v[w]   = ({tr_hi, tr_lo} & ~lowm) | (req_addr & lowm);
    assign meta_v[w] = {pkt, res_id};
  end

  logic        hit_c;
  logic [63:0] xl_c;
  logic [6:0]  meta_c;

  always_comb begin
    hit_c  = 1'b0;
    xl_c   = '0;
    meta_c = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_v[w]) begin
        hit_c  = 1'b1;
        xl_c   = xl_v[w];
        meta_c = meta_v[w];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_addr <= '0;
      rsp_pkt_type <= '0; rsp_res_id <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_hit      <= req_valid && hit_c;
      rsp_addr     <= (req_valid && hit_c) ? xl_c : '0;
      rsp_pkt_type <= (req_valid && hit_c) ? meta_c[6:4] : '0;
      rsp_res_id   <= (req_valid && hit_c) ? meta_c[3:0] : '0;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_pkt_type == '0 && rsp_res_id == '0));
  a_r4_offset_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_addr[0] == $past(req_addr[0])));
endmodule

// File: tb/tb_xlat_window_table.sv
module tb_xlat_window_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [63:0] rsp_addr;
  logic [2:0]  rsp_pkt_type;
  logic [3:0]  rsp_res_id;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_window_table dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_pkt_type(rsp_pkt_type), .rsp_res_id(rsp_res_id)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prog(int n, logic [63:0] src, logic [5:0] code, logic en,
                      logic [63:0] tr, logic [31:0] prm);
    logic [11:0] b;
    b = 12'h800 + 12'(n * 32);
    wr(b + 12'h00, {src[31:7], code, en});
    wr(b + 12'h04, src[63:32]);
    wr(b + 12'h08, tr[31:0]);
    wr(b + 12'h0C, tr[63:32]);
    wr(b + 12'h10, prm);
  endtask

  task automatic lookup(string tag, logic [63:0] a, logic hit, logic [63:0] xa,
                        logic [2:0] pt, logic [3:0] id);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " hit"}, 64'(rsp_hit), 64'(hit));
    chk({tag, " addr"}, rsp_addr, xa);
    chk({tag, " type"}, 64'(rsp_pkt_type), 64'(pt));
    chk({tag, " id"}, 64'(rsp_res_id), 64'(id));
  endtask

  task automatic t_reset;
    chk("R9 reset valid", 64'(rsp_valid), 64'd0);
    chk("R9 reset hit", 64'(rsp_hit), 64'd0);
    lookup("R9 empty table miss", 64'h0000_0000_4000_0000, 1'b0, 64'd0, 3'd0, 4'd0);
  endtask

  task automatic t_mem_window;
    prog(0, 64'h0000_0000_4000_0000, 6'd19, 1'b1, 64'h0000_0001_2000_0000, 32'h0);
    lookup("R3 R4 mem hit", 64'h0000_0000_4001_2345, 1'b1, 64'h0000_0001_2001_2345, 3'd0, 4'd0);
    @(negedge clk);
    chk("R7 idle after request", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_io_window;
    prog(3, 64'h0000_00FF_0000_0000, 6'd15, 1'b1, 64'h1234_0000_0000_5555, 32'h0002_0001);
    lookup("R5 R4 io hit", 64'h0000_00FF_0000_ABCD, 1'b1, 64'h1234_0000_0000_ABCD, 3'd2, 4'd1);
  endtask

  task automatic t_edges;
    lookup("R3 top byte", 64'h0000_0000_400F_FFFF, 1'b1, 64'h0000_0001_200F_FFFF, 3'd0, 4'd0);
    lookup("R8 above window", 64'h0000_0000_4010_0000, 1'b0, 64'd0, 3'd0, 4'd0);
    lookup("R8 below window", 64'h0000_0000_3FFF_FFFF, 1'b0, 64'd0, 3'd0, 4'd0);
    lookup("R3 high word differs", 64'h0000_0001_4000_0000, 1'b0, 64'd0, 3'd0, 4'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h0000_0000_4000_0008;
    @(negedge clk);
    chk("R7 first result valid", 64'(rsp_valid), 64'd1);
    chk("R7 first result addr", rsp_addr, 64'h0000_0001_2000_0008);
    req_addr = 64'h0000_00FF_0000_0010;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 second result valid", 64'(rsp_valid), 64'd1);
    chk("R7 second result addr", rsp_addr, 64'h1234_0000_0000_0010);
    chk("R7 second result type", 64'(rsp_pkt_type), 64'd2);
    @(negedge clk);
    chk("R7 drops after burst", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_priority;
    prog(5, 64'h0000_0000_4000_0000, 6'd29, 1'b1, 64'h0000_0008_0000_0000, 32'h0);
    lookup("R6 lower window wins", 64'h0000_0000_4000_0010, 1'b1, 64'h0000_0001_2000_0010, 3'd0, 4'd0);
    lookup("R6 only upper window", 64'h0000_0000_5000_0000, 1'b1, 64'h0000_0008_1000_0000, 3'd0, 4'd0);
    wr(12'h800, {25'h0800000, 6'd19, 1'b0});
    lookup("R10 disabled window skipped", 64'h0000_0000_4000_0010, 1'b1, 64'h0000_0008_0000_0010, 3'd0, 4'd0);
  endtask

  task automatic t_ignored_writes;
    wr(12'h814, 32'hFFFF_FFFF);
    wr(12'h900, 32'hFFFF_FFFF);
    wr(12'h7FC, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    lookup("R1 stray writes ignored", 64'h0000_0000_4000_0010, 1'b1, 64'h0000_0008_0000_0010, 3'd0, 4'd0);
    lookup("R1 stray writes no new window", 64'h0000_0002_0000_0000, 1'b0, 64'd0, 3'd0, 4'd0);
  endtask

  task automatic t_full_span;
    prog(7, 64'h0, 6'd63, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0002_0001);
    lookup("R2 full span passes address", 64'hDEAD_BEEF_0000_1234, 1'b1, 64'hDEAD_BEEF_0000_1234, 3'd2, 4'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_window();
    t_io_window();
    t_edges();
    t_back_to_back();
    t_priority();
    t_ignored_writes();
    t_full_span();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule